// File: doc/BRIEF.md
# Debug Halt Request Controller

This block decides when a processor core stops for debug. It takes a breakpoint request and turns it into a halt at the right moment, and it picks where execution resumes. A breakpoint request only marks a halt as pending. The core takes the halt at the next instruction boundary, or at once if it is sitting in stop mode.

Right after reset there is a special path. The core spends a fixed delay before it starts reset exception processing. A breakpoint seen early in that delay makes the core halt in place of that processing. While the core is halted from this path, a debugger can set the emulation-mode bit and may load a new program counter.

On a GO command the block reports one of three resume targets: the loaded program counter, the reset exception sequence, or the next sequential instruction. It also keeps a status word with a one-hot halt-source field. That field survives status reads. GO clears part of it.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the first event after its release, `halted` is 0, `pst` is 0x0, `resume_sel` is 0 and `stat_rdata` is 0.
- R2: Clock edges after `rst_n` rises are numbered 0, 1, 2 and so on. If `brk_req` is sampled high at an edge numbered below BRK_WIN, `halted` rises after edge RST_DELAY-1 and not before. With defaults, that is after the 16th edge.
- R3: If `brk_req` is high only at edges BRK_WIN..RST_DELAY-1, no reset-time halt occurs. The request is kept pending and is taken at the first `insn_bound` once running.
- R4: While running, a sampled `brk_req` sets a pending halt. The halt is entered at the edge where `insn_bound` is high and the request or pending flag is present. Entering a halt clears the pending flag. `brk_req` seen while halted is ignored.
- R5: While running with `stop_mode` high, a breakpoint request or pending halt enters the halt at the next edge without any `insn_bound`.
- R6: `pst` is 0xF while halted and 0x0 otherwise.
- R7: The halt-source field occupies status bits [27:24] and is one-hot at each halt entry. Bit 27 means `brk_req` was still high at entry. Bit 26 means a reset-window halt. Bit 25 means a stop-mode wake-up. Bit 24 means an instruction-boundary halt. When several apply, the highest bit wins. Bit 27, once set, stays set until reset.
- R8: GO while halted clears bits [26:24] and keeps bit 27. A status read changes no bit.
- R9: GO while halted sets `resume_sel` to one of three codes. Code 1 (loaded PC) applies if `cmd_pc_wr` was seen during that halt. Otherwise code 2 (reset exception) applies after a reset-window halt. Otherwise code 3 (next instruction) applies. GO and `cmd_pc_wr` are ignored while not halted.
- R10: The emulation bit (status bit 5) takes `emu_wdata` on `cmd_emu_wr` only while halted from the reset window. Writes at any other time are ignored. Reset clears the bit.
- R11: `cmd_csr_rd` loads the current status word into `stat_rdata` one edge later. `stat_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_req | input | 1 | Breakpoint request |
| insn_bound | input | 1 | Instruction boundary strobe (halt sample point) |
| stop_mode | input | 1 | Core is stopped by a stop instruction |
| cmd_go | input | 1 | Debug GO command |
| cmd_pc_wr | input | 1 | Debug write of the program counter |
| cmd_csr_rd | input | 1 | Debug read of the status word |
| cmd_emu_wr | input | 1 | Debug write of the emulation bit |
| emu_wdata | input | 1 | Value for the emulation bit |
| halted | output | 1 | Core is halted |
| pst | output | 4 | Processor status nibble |
| resume_sel | output | 2 | Resume target chosen by the last accepted GO |
| stat_rdata | output | 32 | Status word returned by the last read |

## Verification
The reset window is probed with three kinds of request. A pulse early in the window shows that the halt is held off until the full delay has run. A pulse late in the window shows that it becomes an ordinary pending halt. A request held through the whole window shows bit 27 winning over bit 26. While running, two cases are compared. A request pulsed without a boundary tests that the pending latch keeps it until `insn_bound`. In stop mode, a live request and an already pending one enter the halt on different source bits. GO is issued after PC writes, without them, and outside a halt, which separates the three resume codes from an ignored command.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

   typedef enum logic [1:0] {
      ST_RWAIT = 2'd0,
      ST_RUN   = 2'd1,
      ST_HALT  = 2'd2
   } hstate_t;

   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_PC    = 2'd1,
      RES_RESET = 2'd2,
      RES_NEXT  = 2'd3
   } resume_t;

   localparam int SRC_W     = 4;
   localparam int CAUSE_BND = 0;
   localparam int CAUSE_STP = 1;
   localparam int CAUSE_RWN = 2;
   localparam int CAUSE_BRK = 3;

   localparam logic [3:0] PST_RUN  = 4'h0;
   localparam logic [3:0] PST_HALT = 4'hF;

endpackage

// File: rtl/dbg_rst_window.sv
module dbg_rst_window #(
   parameter int RST_DELAY = 16,
   parameter int BRK_WIN   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic brk_req,
   output logic win_now,
   output logic win_last,
   output logic late_brk
);
   localparam int CNT_W = (RST_DELAY > 2) ? $clog2(RST_DELAY) : 1;

   if (BRK_WIN < 1 || BRK_WIN > RST_DELAY) begin : g_bad_win
      $error("dbg_rst_window: BRK_WIN must lie in 1..RST_DELAY");
   end
   if (RST_DELAY < 2) begin : g_bad_dly
      $error("dbg_rst_window: RST_DELAY must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             hit_q;
   logic             in_win;

   assign in_win   = int'(cnt_q) < BRK_WIN;
   assign win_last = active && (cnt_q == CNT_W'(RST_DELAY - 1));
   assign win_now  = hit_q || (active && brk_req && in_win);
   assign late_brk = active && brk_req && !in_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else if (!active) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else begin
         if (!win_last) cnt_q <= cnt_q + CNT_W'(1);
         if (brk_req && in_win) hit_q <= 1'b1;
      end
   end

endmodule

// File: rtl/dbg_halt_src.sv
module dbg_halt_src #(
   parameter int  SRC_W      = 4,
   parameter bit  STICKY_MSB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enter,
   input  logic [SRC_W-1:0] cause,
   input  logic             go_clr,
   output logic [SRC_W-1:0] src_q
);
   if (SRC_W < 2) begin : g_bad_w
      $error("dbg_halt_src: SRC_W must be at least 2");
   end

   logic [SRC_W-1:0] winner;
   logic [SRC_W-1:0] keep;

   always_comb begin
      winner = '0;
      for (int i = 0; i < SRC_W; i++) begin
         if (cause[i]) begin
            winner    = '0;
            winner[i] = 1'b1;
         end
      end
   end

   if (STICKY_MSB) begin : g_sticky
      assign keep = {src_q[SRC_W-1], {(SRC_W-1){1'b0}}};
   end else begin : g_plain
      assign keep = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      src_q <= '0;
      else if (enter)  src_q <= keep | winner;
      else if (go_clr) src_q <= keep;
   end

   // R8
   go_clears_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_clr && !enter |=> src_q[SRC_W-2:0] == '0);

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
   import dbg_halt_pkg::*;
#(
   parameter int RST_DELAY = 16,
   parameter int BRK_WIN   = 8,
   parameter int STAT_W    = 32,
   parameter int SRC_LSB   = 24,
   parameter int EMU_BIT   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              brk_req,
   input  logic              insn_bound,
   input  logic              stop_mode,
   input  logic              cmd_go,
   input  logic              cmd_pc_wr,
   input  logic              cmd_csr_rd,
   input  logic              cmd_emu_wr,
   input  logic              emu_wdata,
   output logic              halted,
   output logic [3:0]        pst,
   output logic [1:0]        resume_sel,
   output logic [STAT_W-1:0] stat_rdata
);
   if (SRC_LSB + SRC_W > STAT_W || EMU_BIT >= STAT_W) begin : g_bad_map
      $error("dbg_halt_ctrl: status fields exceed STAT_W");
   end
   if (EMU_BIT >= SRC_LSB && EMU_BIT < SRC_LSB + SRC_W) begin : g_overlap
      $error("dbg_halt_ctrl: emulation bit overlaps source field");
   end

   hstate_t          st_q, st_d;
   resume_t          res_q, res_d;
   logic             pend_q, pend_d;
   logic             rsth_q, rsth_d;
   logic             pcl_q, pcl_d;
   logic             emu_q, emu_d;
   logic             enter, go_clr;
   logic [SRC_W-1:0] cause;
   logic [SRC_W-1:0] src_q;
   logic             win_now, win_last, late_brk;
   logic             take;
   logic [STAT_W-1:0] stat_word;

   dbg_rst_window #(.RST_DELAY(RST_DELAY), .BRK_WIN(BRK_WIN)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (st_q == ST_RWAIT),
      .brk_req  (brk_req),
      .win_now  (win_now),
      .win_last (win_last),
      .late_brk (late_brk)
   );

   dbg_halt_src #(.SRC_W(SRC_W), .STICKY_MSB(1'b1)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .enter  (enter),
      .cause  (cause),
      .go_clr (go_clr),
      .src_q  (src_q)
   );

   assign take = brk_req || pend_q;

   always_comb begin
      st_d   = st_q;
      res_d  = res_q;
      pend_d = pend_q;
      rsth_d = rsth_q;
      pcl_d  = pcl_q;
      emu_d  = emu_q;
      enter  = 1'b0;
      go_clr = 1'b0;
      cause  = '0;
      unique case (st_q)
         ST_RWAIT: begin
            if (late_brk) pend_d = 1'b1;
            if (win_last) begin
               if (win_now) begin
                  st_d             = ST_HALT;
                  enter            = 1'b1;
                  cause[CAUSE_BRK] = brk_req;
                  cause[CAUSE_RWN] = 1'b1;
                  rsth_d           = 1'b1;
                  pend_d           = 1'b0;
               end else begin
                  st_d = ST_RUN;
               end
            end
         end
         ST_RUN: begin
            if (take && (stop_mode || insn_bound)) begin
               st_d             = ST_HALT;
               enter            = 1'b1;
               cause[CAUSE_BRK] = brk_req;
               cause[CAUSE_STP] = stop_mode;
               cause[CAUSE_BND] = !stop_mode;
               pend_d           = 1'b0;
            end else if (brk_req) begin
               pend_d = 1'b1;
            end
         end
         ST_HALT: begin
            if (cmd_go) begin
               st_d   = ST_RUN;
               go_clr = 1'b1;
               res_d  = pcl_q ? RES_PC : (rsth_q ? RES_RESET : RES_NEXT);
               rsth_d = 1'b0;
               pcl_d  = 1'b0;
            end else begin
               if (cmd_pc_wr) pcl_d = 1'b1;
               if (cmd_emu_wr && rsth_q) emu_d = emu_wdata;
            end
         end
         default: st_d = ST_RWAIT;
      endcase
   end

   always_comb begin
      stat_word                            = '0;
      stat_word[SRC_LSB +: SRC_W]          = src_q;
      stat_word[EMU_BIT]                   = emu_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_RWAIT;
         res_q      <= RES_NONE;
         pend_q     <= 1'b0;
         rsth_q     <= 1'b0;
         pcl_q      <= 1'b0;
         emu_q      <= 1'b0;
         stat_rdata <= '0;
      end else begin
         st_q   <= st_d;
         res_q  <= res_d;
         pend_q <= pend_d;
         rsth_q <= rsth_d;
         pcl_q  <= pcl_d;
         emu_q  <= emu_d;
         if (cmd_csr_rd) stat_rdata <= stat_word;
      end
   end

   assign halted     = (st_q == ST_HALT);
   assign pst        = halted ? PST_HALT : PST_RUN;
   assign resume_sel = res_q;

   // R2
   rwait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RWAIT) && !win_last |=> !halted);

   // R4
   run_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN) && !insn_bound && !stop_mode |=> !halted);

   // R8
   halt_src_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted && !cmd_go |=> $stable(src_q));

   // R9
   resume_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(halted && cmd_go) |=> $stable(resume_sel));

   // R10
   emu_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(halted && rsth_q) |=> $stable(emu_q));

endmodule

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
   localparam int RST_DELAY = 16;
   localparam int BRK_WIN   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        brk_req = 0, insn_bound = 0, stop_mode = 0;
   logic        cmd_go = 0, cmd_pc_wr = 0, cmd_csr_rd = 0;
   logic        cmd_emu_wr = 0, emu_wdata = 0;
   logic        halted;
   logic [3:0]  pst;
   logic [1:0]  resume_sel;
   logic [31:0] stat_rdata;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   dbg_halt_ctrl #(.RST_DELAY(RST_DELAY), .BRK_WIN(BRK_WIN)) dut (
      .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .insn_bound(insn_bound),
      .stop_mode(stop_mode), .cmd_go(cmd_go), .cmd_pc_wr(cmd_pc_wr),
      .cmd_csr_rd(cmd_csr_rd), .cmd_emu_wr(cmd_emu_wr), .emu_wdata(emu_wdata),
      .halted(halted), .pst(pst), .resume_sel(resume_sel), .stat_rdata(stat_rdata)
   );

   // behavioural reference: 0 = reset wait, 1 = running, 2 = halted
   int m_state = 0, m_cnt = 0, m_res = 0, m_src = 0;
   bit m_winp = 0, m_pend = 0, m_rsth = 0, m_pcl = 0, m_emu = 0;
   int unsigned m_rdata = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_res = 0; m_src = 0; m_winp = 0;
         m_pend = 0; m_rsth = 0; m_pcl = 0; m_emu = 0; m_rdata = 0;
      end else begin
         if (cmd_csr_rd) m_rdata = (m_src << 24) | (m_emu << 5);
         if (m_state == 0) begin
            bit early;
            early = brk_req && (m_cnt < BRK_WIN);
            if (brk_req && !early) m_pend = 1;
            if (m_cnt == RST_DELAY - 1) begin
               if (m_winp || early) begin
                  m_state = 2; m_rsth = 1; m_pend = 0;
                  m_src = (m_src & 8) | (brk_req ? 8 : 4);
               end else m_state = 1;
            end else m_cnt++;
            if (early) m_winp = 1;
         end else if (m_state == 1) begin
            if ((brk_req || m_pend) && (stop_mode || insn_bound)) begin
               m_state = 2; m_pend = 0;
               m_src = (m_src & 8) | (brk_req ? 8 : (stop_mode ? 2 : 1));
            end else if (brk_req) m_pend = 1;
         end else begin
            if (cmd_go) begin
               m_res = m_pcl ? 1 : (m_rsth ? 2 : 3);
               m_src = m_src & 8; m_rsth = 0; m_pcl = 0; m_state = 1;
            end else begin
               if (cmd_pc_wr) m_pcl = 1;
               if (cmd_emu_wr && m_rsth) m_emu = emu_wdata;
            end
         end
      end
   end

   task automatic chk(input string req, input int unsigned act, input int unsigned exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 halted vs model", halted, (m_state == 2));
         chk("R6 pst vs model", pst, (m_state == 2) ? 4'hF : 4'h0);
         chk("R9 resume vs model", resume_sel, m_res);
         chk("R11 rdata vs model", stat_rdata, m_rdata);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic pulse_go();
      cmd_go = 1; step(1); cmd_go = 0;
   endtask

   task automatic read_stat(input string req, input int unsigned exp);
      cmd_csr_rd = 1; step(1); cmd_csr_rd = 0;
      chk(req, stat_rdata, exp);
   endtask

   task automatic do_reset();
      rst_n = 0; step(3);
      rst_n = 1;
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1 reset state
      chk("R1 halted", halted, 0);
      chk("R1 pst", pst, 0);
      chk("R1 resume", resume_sel, 0);
      chk("R1 rdata", stat_rdata, 0);

      // R2 early pulse: halt only at the end of the delay
      rst_n = 1; step(2);
      brk_req = 1; step(1); brk_req = 0;
      step(12);
      chk("R2 not before delay", halted, 0);
      step(1);
      chk("R2 halted after delay", halted, 1);
      chk("R6 pst halted", pst, 4'hF);
      read_stat("R7 reset window source", 32'h0400_0000);
      read_stat("R8 read keeps source", 32'h0400_0000);
      cmd_emu_wr = 1; emu_wdata = 1; step(1); cmd_emu_wr = 0; emu_wdata = 0;
      read_stat("R10 emu write in reset halt", 32'h0400_0020);
      pulse_go();
      chk("R9 resume reset exception", resume_sel, 2);
      read_stat("R8 GO clears low bits", 32'h0000_0020);

      // R4 pending halt waits for boundary
      brk_req = 1; step(1); brk_req = 0;
      step(3);
      chk("R4 pending no boundary", halted, 0);
      insn_bound = 1; step(1); insn_bound = 0;
      chk("R4 halted at boundary", halted, 1);
      read_stat("R7 boundary source", 32'h0100_0020);
      brk_req = 1;
      cmd_emu_wr = 1; emu_wdata = 0; step(1); cmd_emu_wr = 0; brk_req = 0;
      read_stat("R10 emu write ignored", 32'h0100_0020);
      cmd_pc_wr = 1; step(1); cmd_pc_wr = 0;
      pulse_go();
      chk("R9 resume loaded PC", resume_sel, 1);
      insn_bound = 1; step(2); insn_bound = 0;
      chk("R4 brk during halt ignored", halted, 0);

      // R5 stop wake with live request
      stop_mode = 1; brk_req = 1; step(1); brk_req = 0;
      chk("R5 stop wake", halted, 1);
      stop_mode = 0;
      read_stat("R7 live brk wins", 32'h0800_0020);
      pulse_go();
      chk("R9 resume next", resume_sel, 3);
      read_stat("R8 bit27 kept", 32'h0800_0020);

      // R5 stop wake from pending
      brk_req = 1; step(1); brk_req = 0;
      step(2);
      chk("R4 pending held", halted, 0);
      stop_mode = 1; step(1); stop_mode = 0;
      chk("R5 pending stop wake", halted, 1);
      read_stat("R7 stop source", 32'h0A00_0020);
      pulse_go();

      // R3 late pulse: no reset halt
      do_reset();
      step(10);
      brk_req = 1; step(1); brk_req = 0;
      step(5);
      chk("R3 no reset halt", halted, 0);
      step(3);
      chk("R3 still running", halted, 0);
      insn_bound = 1; step(1); insn_bound = 0;
      chk("R3 pending taken", halted, 1);
      cmd_emu_wr = 1; emu_wdata = 1; step(1); cmd_emu_wr = 0; emu_wdata = 0;
      read_stat("R10 emu ignored after reset", 32'h0100_0000);
      pulse_go();
      chk("R9 resume next", resume_sel, 3);

      // R7 held request wins over reset-window source
      do_reset();
      brk_req = 1; step(RST_DELAY); brk_req = 0;
      chk("R2 halted held request", halted, 1);
      read_stat("R7 bit27 over bit26", 32'h0800_0000);
      pulse_go();
      chk("R9 resume reset", resume_sel, 2);
      insn_bound = 1; step(2); insn_bound = 0;
      chk("R4 pending cleared at entry", halted, 0);
      pulse_go();
      chk("R9 GO outside halt ignored", resume_sel, 2);
      cmd_pc_wr = 1; step(1); cmd_pc_wr = 0;
      brk_req = 1; insn_bound = 1; step(1); brk_req = 0; insn_bound = 0;
      chk("R4 halted again", halted, 1);
      pulse_go();
      chk("R9 PC write outside halt ignored", resume_sel, 3);
      step(2);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule